// File: doc/BRIEF.md
# Carrier Interrupt Aggregation Controller

This block collects the interrupt requests of a carrier board with several plug-in module slots and merges them onto one host interrupt line. Every slot has two request inputs. A control byte per slot enables each input and selects edge or level handling for it. A status word records which requests are pending. The host reads and writes the control bytes and the status word through a plain 16-bit register port addressed by a byte offset. The host can also issue an acknowledge read into a slot's interrupt space.

Level-mode requests hold the host line high while any of them is pending. Edge-mode requests never hold the line. Each edge-mode rising request instead inverts the host line for a single clock cycle, and the line then returns to its held level. A pending bit is cleared by writing a one to it, by an acknowledge read (level mode only), or when its enabled input falls.

The register port, the acknowledge strobe and the host line are plain control pins with no handshake. An access completes in the cycle it is presented, and read data is combinational while `reg_rd` is high.

Top module: `carrier_irq_agg`

## Requirements
- R1: After reset every control byte and the status word read zero, and `host_irq` is low.
- R2: The control byte of slot s sits at byte offset 0x02+2*s (0x02 to 0x08 for four slots). It reads back in bits 7:0, and bits 15:8 read zero. Offsets 0x00 (revision) and 0x0A (reset), and every offset other than 0x0C and the control bytes, read zero and ignore writes. `reg_rdata` is zero whenever `reg_rd` is low.
- R3: A change on request input slot*2+n has no effect on status bit slot*2+n while enable bit 6+n of that slot's control byte is clear.
- R4: While bit 6+n is set, a change on input slot*2+n copies the input's new level into status bit slot*2+n one clock later. The status word is read at offset 0x0C.
- R5: Writing to offset 0x0C clears each status bit 0..7 whose data bit is one. Data bits 8..15 are ignored, and status bits 8..15 always read zero.
- R6: An acknowledge read with `ack_off` 0 targets INT0 of `ack_slot`, and one with `ack_off` 2 targets INT1. It clears that pending bit only when edge bit 4+n of the slot is clear (level mode). Other offsets do nothing.
- R7: Outside edge pulses, `host_irq` is high exactly when some pending status bit whose source is in level mode is set. It follows one clock after the status change.
- R8: An enabled edge-mode input whose rise sets its status bit from 0 to 1 inverts `host_irq` for exactly one cycle, one clock after the rise. Afterwards `host_irq` returns to the held level.
- R9: A rise on an edge-mode input whose status bit is already set causes no pulse, and `host_irq` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_irq | input | 8 | Module request inputs, bit slot*2+n, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, zero when not reading |
| ack_rd | input | 1 | Acknowledge read into a slot's interrupt space |
| ack_slot | input | 2 | Slot of the acknowledge read |
| ack_off | input | 6 | Offset within the interrupt space |
| host_irq | output | 1 | Merged host interrupt line |

## Verification
The assertions assume that `mod_irq` is already synchronous to `clk`, so that a change is seen by exactly one edge. They also assume that register accesses and acknowledge reads are single-cycle strobes whose data is stable around the edge. The bench changes every input only on the falling clock edge. Each stimulus step presents at most one access or one input change, so the status word and the host line can be predicted a cycle at a time. The clear and acknowledge properties apply only in cycles where the request inputs are unchanged, which keeps them from colliding with the rule that an input event wins over a clear.

// File: rtl/carrier_irq_pkg.sv
package carrier_irq_pkg;
  localparam int unsigned INTS_PER_SLOT = 2;
  localparam int unsigned CTRL_W        = 8;
  localparam int unsigned REG_W         = 16;
  localparam int unsigned ADDR_W        = 8;
  localparam int unsigned AOFS_W        = 6;
  // control byte layout: edge selects, then enables, per request line
  localparam int unsigned EDGE_LSB      = 4;
  localparam int unsigned ENA_LSB       = EDGE_LSB + INTS_PER_SLOT;
  localparam int unsigned CTRL_BASE     = 2;
endpackage

// File: rtl/slot_ctrl_regs.sv
module slot_ctrl_regs
  import carrier_irq_pkg::*;
#(
  parameter int unsigned NSLOT = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [CTRL_W-1:0]                 wdata,
  output logic [NSLOT-1:0][CTRL_W-1:0]      ctrl_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(CTRL_BASE + 2 * s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_o[s] <= '0;
      else if (wr && addr == MY_OFS)
        ctrl_o[s] <= wdata;
    end
  end
endmodule

// File: rtl/irq_status_track.sv
module irq_status_track
  import carrier_irq_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned NB   = NSLOT * INTS_PER_SLOT,
  localparam int unsigned SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSLOT-1:0][CTRL_W-1:0] ctrl,
  input  logic [NB-1:0]                mod_irq,
  input  logic [NB-1:0]                clr,
  input  logic                         ack_rd,
  input  logic [SW-1:0]                ack_slot,
  input  logic [AOFS_W-1:0]            ack_off,
  output logic [NB-1:0]                irq_seen_o,
  output logic [NB-1:0]                status_o,
  output logic [NB-1:0]                status_d_o,
  output logic [NB-1:0]                lvl_mask_o,
  output logic [NB-1:0]                fire_o
);
  logic [NB-1:0] irq_q, st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      st_q  <= '0;
    end else begin
      irq_q <= mod_irq;
      st_q  <= st_d;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_bit
    localparam int unsigned S = i / INTS_PER_SLOT;
    localparam int unsigned N = i % INTS_PER_SLOT;
    logic en, edg, chg, ack_hit;
    assign en      = ctrl[S][ENA_LSB + N];
    assign edg     = ctrl[S][EDGE_LSB + N];
    assign chg     = mod_irq[i] ^ irq_q[i];
    assign ack_hit = ack_rd && (ack_slot == SW'(S)) &&
                     (ack_off == AOFS_W'(2 * N)) && !edg;
    // an enabled input event takes priority over clears in the same cycle
    assign st_d[i]       = (chg && en) ? mod_irq[i] : (st_q[i] && !clr[i] && !ack_hit);
    assign fire_o[i]     = chg && en && edg && mod_irq[i] && !st_q[i];
    assign lvl_mask_o[i] = !edg;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_sink
    logic unused_cfg;
    assign unused_cfg = ^ctrl[s][EDGE_LSB-1:0];
  end

  assign irq_seen_o = irq_q;
  assign status_o   = st_q;
  assign status_d_o = st_d;
endmodule

// File: rtl/host_line_drive.sv
module host_line_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_any,
  input  logic fire_any,
  output logic held_o,
  output logic pulse_o,
  output logic host_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      held_o  <= lvl_any;
      pulse_o <= fire_any;
    end
  end
  assign host_irq = held_o ^ pulse_o;
endmodule

// File: rtl/carrier_irq_agg.sv
module carrier_irq_agg
  import carrier_irq_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned NB   = NSLOT * INTS_PER_SLOT,
  localparam int unsigned SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     mod_irq,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ack_rd,
  input  logic [SW-1:0]     ack_slot,
  input  logic [AOFS_W-1:0] ack_off,
  output logic              host_irq
);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(CTRL_BASE + 2 * NSLOT + 2);

  logic [NSLOT-1:0][CTRL_W-1:0] ctrl_q;
  logic [NB-1:0] status_q, status_d, lvl_mask, fire, irq_seen, clr_vec;
  logic          held, pulse;
  logic          unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[REG_W-1:CTRL_W];
  assign clr_vec = (reg_wr && reg_addr == STAT_OFS) ? reg_wdata[NB-1:0] : '0;

  slot_ctrl_regs #(.NSLOT(NSLOT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[CTRL_W-1:0]), .ctrl_o(ctrl_q)
  );

  irq_status_track #(.NSLOT(NSLOT)) u_track (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .mod_irq(mod_irq), .clr(clr_vec),
    .ack_rd(ack_rd), .ack_slot(ack_slot), .ack_off(ack_off),
    .irq_seen_o(irq_seen), .status_o(status_q), .status_d_o(status_d),
    .lvl_mask_o(lvl_mask), .fire_o(fire)
  );

  host_line_drive u_host (
    .clk(clk), .rst_n(rst_n), .lvl_any(|(status_d & lvl_mask)),
    .fire_any(|fire), .held_o(held), .pulse_o(pulse), .host_irq(host_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == STAT_OFS)
        reg_rdata[NB-1:0] = status_q;
      for (int s = 0; s < NSLOT; s++)
        if (reg_addr == ADDR_W'(CTRL_BASE + 2 * s))
          reg_rdata[CTRL_W-1:0] = ctrl_q[s];
    end
  end
endmodule

// File: rtl/carrier_irq_agg_chk.sv
module carrier_irq_agg_chk
  import carrier_irq_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned NB   = NSLOT * INTS_PER_SLOT,
  localparam int unsigned SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NB-1:0]                mod_irq,
  input logic                         reg_wr,
  input logic                         reg_rd,
  input logic [ADDR_W-1:0]            reg_addr,
  input logic [REG_W-1:0]             reg_wdata,
  input logic [REG_W-1:0]             reg_rdata,
  input logic                         ack_rd,
  input logic [SW-1:0]                ack_slot,
  input logic [AOFS_W-1:0]            ack_off,
  input logic                         host_irq,
  input logic [NSLOT-1:0][CTRL_W-1:0] ctrl_q,
  input logic [NB-1:0]                status_q,
  input logic [NB-1:0]                irq_seen,
  input logic [NB-1:0]                lvl_mask,
  input logic                         pulse
);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(CTRL_BASE + 2 * NSLOT + 2);
  logic any_en;
  always_comb begin
    any_en = 1'b0;
    for (int s = 0; s < NSLOT; s++)
      for (int n = 0; n < INTS_PER_SLOT; n++)
        any_en = any_en | ctrl_q[s][ENA_LSB + n];
  end

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0);

  assert_gate_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !ack_rd && !any_en) |=> $stable(status_q));

  assert_w1c_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STAT_OFS && (&reg_wdata[NB-1:0]) && mod_irq == irq_seen)
    |=> status_q == '0);

  assert_ack_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && ack_slot == '0 && ack_off == '0 && !ctrl_q[0][EDGE_LSB] &&
     mod_irq[0] == irq_seen[0]) |=> !status_q[0]);

  assert_level_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && $stable(lvl_mask)) |-> host_irq == |(status_q & lvl_mask));

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(|(mod_irq & ~irq_seen)));
endmodule

bind carrier_irq_agg carrier_irq_agg_chk #(.NSLOT(NSLOT)) u_chk (.*);

// File: tb/carrier_irq_agg_test.sv
module carrier_irq_agg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_IRQ = 4'd2, OP_ACK = 4'd3;
  localparam int NV = 28;
  // {op, requirement number, addr, data, expected}
  localparam logic [47:0] VEC [NV] = '{
    {OP_RD,  4'd1, 8'h02, 16'h0000, 16'h0000}, // R1 reset control
    {OP_WR,  4'd2, 8'h02, 16'h00C0, 16'h0000},
    {OP_RD,  4'd2, 8'h02, 16'h0000, 16'h00C0}, // R2 readback
    {OP_IRQ, 4'd7, 8'h00, 16'h0001, 16'h0001}, // R7 level high
    {OP_RD,  4'd4, 8'h0C, 16'h0000, 16'h0001}, // R4
    {OP_IRQ, 4'd7, 8'h00, 16'h0003, 16'h0001},
    {OP_RD,  4'd4, 8'h0C, 16'h0000, 16'h0003},
    {OP_WR,  4'd5, 8'h0C, 16'h0001, 16'h0000},
    {OP_RD,  4'd5, 8'h0C, 16'h0000, 16'h0002}, // R5 one bit cleared
    {OP_ACK, 4'd6, 8'h02, 16'h0000, 16'h0000}, // R6 slot0 INT1 ack, host low
    {OP_RD,  4'd6, 8'h0C, 16'h0000, 16'h0000},
    {OP_IRQ, 4'd4, 8'h00, 16'h0000, 16'h0000},
    {OP_IRQ, 4'd3, 8'h00, 16'h0004, 16'h0000}, // R3 disabled slot
    {OP_RD,  4'd3, 8'h0C, 16'h0000, 16'h0000},
    {OP_WR,  4'd2, 8'h04, 16'h0050, 16'h0000},
    {OP_RD,  4'd4, 8'h0C, 16'h0000, 16'h0000},
    {OP_IRQ, 4'd8, 8'h00, 16'h0000, 16'h0000}, // R8 fall gives no pulse
    {OP_WR,  4'd5, 8'h0C, 16'hFF00, 16'h0000},
    {OP_RD,  4'd5, 8'h0C, 16'h0000, 16'h0000},
    {OP_WR,  4'd2, 8'h00, 16'h1234, 16'h0000},
    {OP_RD,  4'd2, 8'h00, 16'h0000, 16'h0000},
    {OP_RD,  4'd2, 8'h0A, 16'h0000, 16'h0000},
    {OP_WR,  4'd2, 8'h0E, 16'hFFFF, 16'h0000},
    {OP_RD,  4'd2, 8'h0E, 16'h0000, 16'h0000},
    {OP_WR,  4'd2, 8'h06, 16'hFFAB, 16'h0000},
    {OP_RD,  4'd2, 8'h06, 16'h0000, 16'h00AB},
    {OP_RD,  4'd2, 8'h08, 16'h0000, 16'h0000},
    {OP_RD,  4'd2, 8'h04, 16'h0000, 16'h0050}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  mod_irq = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, ack_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  ack_slot = '0;
  logic [5:0]  ack_off = '0;
  logic        host_irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carrier_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .mod_irq(mod_irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_rd(ack_rd), .ack_slot(ack_slot), .ack_off(ack_off), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [15:0] exp);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
    reg_rd = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    mod_irq = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic [1:0] s, input logic [5:0] o);
    ack_rd = 1'b1; ack_slot = s; ack_off = o;
    @(negedge clk);
    ack_rd = 1'b0;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {15'b0, host_irq}, 16'h0000);
    rd("R1", 8'h0C, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[k][43:40]);
      case (VEC[k][47:44])
        OP_WR:  wr(VEC[k][39:32], VEC[k][31:16]);
        OP_RD:  rd(tag, VEC[k][39:32], VEC[k][15:0]);
        OP_IRQ: begin
          set_irq(VEC[k][23:16]);
          chk(tag, {15'b0, host_irq}, VEC[k][15:0]);
        end
        default: begin
          ack(VEC[k][39:38], VEC[k][37:32]);
          chk(tag, {15'b0, host_irq}, VEC[k][15:0]);
        end
      endcase
    end

    // R8 edge pulse from a low held level
    set_irq(8'h04);
    chk("R8", {15'b0, host_irq}, 16'h0001);
    @(negedge clk);
    chk("R8", {15'b0, host_irq}, 16'h0000);
    rd("R4", 8'h0C, 16'h0004);
    ack(2'd1, 6'd0);
    rd("R6", 8'h0C, 16'h0004);           // edge mode: ack leaves it pending
    wr(8'h0C, 16'h0004);
    rd("R5", 8'h0C, 16'h0000);

    // R8 inversion while the held level is high
    set_irq(8'h05);
    chk("R7", {15'b0, host_irq}, 16'h0001);
    set_irq(8'h01);
    chk("R8", {15'b0, host_irq}, 16'h0001);
    set_irq(8'h05);
    chk("R8", {15'b0, host_irq}, 16'h0000);
    @(negedge clk);
    chk("R8", {15'b0, host_irq}, 16'h0001);

    // R9 rise with the status bit already set
    wr(8'h04, 16'h0010);
    set_irq(8'h01);
    rd("R3", 8'h0C, 16'h0005);
    wr(8'h04, 16'h0050);
    set_irq(8'h05);
    chk("R9", {15'b0, host_irq}, 16'h0001);
    @(negedge clk);
    chk("R9", {15'b0, host_irq}, 16'h0001);
    rd("R9", 8'h0C, 16'h0005);

    // R7 only level-mode bits hold the line
    ack(2'd0, 6'd0);
    chk("R7", {15'b0, host_irq}, 16'h0000);
    rd("R6", 8'h0C, 16'h0004);

    // R1 reset in mid run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mod_irq = '0;
    @(negedge clk);
    chk("R1", {15'b0, host_irq}, 16'h0000);
    rd("R1", 8'h04, 16'h0000);
    rd("R1", 8'h0C, 16'h0000);

    finish_run();
  end
endmodule